// File: doc/BRIEF.md
# Configurable Pixel Clock Generator

This block derives a display pixel clock, and a matching one-cycle pixel-rate enable, from a fast module clock. The division happens in two stages. The first stage is a pre-divider whose average ratio is an integer plus a fraction given as a numerator/denominator pair. It produces pre-periods of integer or integer+1 module cycles. The second stage is an integer post-divider that groups (N+1) pre-periods into one pixel period. The second stage can be bypassed, and then each pre-period becomes one pixel period. Separate controls set the level the pixel clock rests at while idle and the level it takes in the first half of every period.

Everything is programmed through one 32-bit configuration word, and a run request starts and stops the clock. A 2-bit source field models clock-source selection only as a gate: zero stops the block, and any other value lets it run. The active configuration is captured at pixel-period boundaries or while idle, so the output never shows a shortened half-period. Both outputs are registered in the module clock domain.

Top module: `pclk_gen`

## Requirements
- R1: During reset, and in the cycle after it is released, `pclk` and `pix_en` are 0.
- R2: While the block is not running, `pclk` follows bit 7 of the configuration word (1 high, 0 low) one cycle later.
- R3: With bit 6 (bypass) set, a pixel period is one pre-period of P module cycles. Its first half lasts ceil(P/2) cycles, and bits 5:0 (N) have no effect. Bypass assumes an integer part of at least 2.
- R4: With bit 6 clear, a pixel period is N+1 pre-periods. The first half takes ceil((N+1)/2) of them and the second half floor((N+1)/2), so an odd count makes the first half longer by one pre-period.
- R5: With bit 6 clear, N = 0 behaves exactly as N = 1.
- R6: The integer part is bits 16:9, the numerator bits 22:17 and the denominator bits 28:23. When 0 < numerator < denominator, an accumulator starting at 0 on each start adds the numerator at every pre-period end. Whenever the sum reaches the denominator, the denominator is subtracted and the next pre-period is one cycle longer.
- R7: A zero numerator, a zero denominator, or a numerator not below the denominator gives integer-only pre-periods.
- R8: An integer part of 0 gives pre-periods of 256 cycles.
- R9: When bits 30:29 are 0, the block does not start, and a running clock stops as if run were low.
- R10: When run falls, the current half-period completes. `pclk` then takes the idle level and `pix_en` stays low.
- R11: Bit 8 sets the `pclk` level in the first half of each period (1 high, 0 low). `pix_en` is high for exactly the first cycle of each period, including the first period after a start.
- R12: A configuration change made mid-period has no effect on the current period and applies from the next period boundary.
- R13: Bit 31 has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 32 | Configuration word |
| run | input | 1 | Run request, high to generate the pixel clock |
| pclk | output | 1 | Pixel clock level |
| pix_en | output | 1 | One-cycle pulse at the start of each pixel period |

## Verification
The divider is driven in bypass mode with plain integer ratios, and with the post-divider set to even and odd N+1. These patterns tell the halving of a pre-period apart from the halving in whole pre-periods, and show which half takes the extra unit on odd counts. Fractional settings with a valid numerator are set against settings where the numerator is not below the denominator, which separates the stretch sequence from integer fallback. An integer part of 0 and an N of 0 probe the two wrap rules. Run and source-select removal, a mid-period reconfiguration and a set force bit show when stopping and reconfiguration take effect and that the force bit is ignored. A per-cycle reference model runs alongside all of these checks.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
  localparam int POST_W = 6;
  localparam int INT_W  = 8;
  localparam int FRAC_W = 6;
  localparam int SRC_W  = 2;
  localparam int PER_W  = INT_W + 2;
  localparam int TCNT_W = POST_W + 1;

  // field order fixed by the configuration word, MSB first
  typedef struct packed {
    logic              force_on;
    logic [SRC_W-1:0]  src;
    logic [FRAC_W-1:0] den;
    logic [FRAC_W-1:0] num;
    logic [INT_W-1:0]  idiv;
    logic              lead_lvl;
    logic              rest_lvl;
    logic              bypass;
    logic [POST_W-1:0] post_n;
  } pclk_cfg_t;

  typedef logic [TCNT_W-1:0] tcnt_t;
  typedef logic [PER_W-1:0]  per_t;

  // pre-period length in module cycles for an integer field
  function automatic per_t base_len(input logic [INT_W-1:0] i);
    return (i == '0) ? per_t'(1 << INT_W) : per_t'(i);
  endfunction

  // accumulator step: {stretch, new accumulator}
  function automatic logic [FRAC_W:0] frac_next(input logic [FRAC_W-1:0] acc,
                                                input logic [FRAC_W-1:0] num,
                                                input logic [FRAC_W-1:0] den);
    logic [FRAC_W:0] sum;
    logic [FRAC_W:0] rem;
    if (num == '0 || den == '0 || num >= den) return '0;
    sum = {1'b0, acc} + {1'b0, num};
    if (sum >= {1'b0, den}) begin
      rem = sum - {1'b0, den};
      if (rem >= {1'b0, den}) rem = '0;
      return {1'b1, rem[FRAC_W-1:0]};
    end
    return {1'b0, sum[FRAC_W-1:0]};
  endfunction

  function automatic tcnt_t post_total(input logic [POST_W-1:0] n);
    return (n == '0) ? tcnt_t'(2) : ({1'b0, n} + 1'b1);
  endfunction

  function automatic tcnt_t post_first(input logic [POST_W-1:0] n);
    tcnt_t t;
    t = post_total(n);
    return (t + 1'b1) >> 1;
  endfunction

  function automatic tcnt_t post_second(input logic [POST_W-1:0] n);
    return post_total(n) >> 1;
  endfunction

  function automatic per_t pre_first(input per_t p);
    return (p + 1'b1) >> 1;
  endfunction
endpackage

// File: rtl/pclk_prediv.sv
module pclk_prediv
  import pclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              restart,
  input  logic [INT_W-1:0]  idiv,
  input  logic [FRAC_W-1:0] num,
  input  logic [FRAC_W-1:0] den,
  output logic              tick,
  output logic              half,
  output per_t              per_len
);
  per_t              cnt;
  logic [FRAC_W-1:0] acc;
  logic [FRAC_W:0]   step;

  assign step = frac_next(acc, num, den);
  assign tick = active && (cnt == per_len - 1'b1);
  assign half = active && (per_len >= per_t'(2)) &&
                (cnt == pre_first(per_len) - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      acc     <= '0;
      per_len <= per_t'(1);
    end else if (restart) begin
      cnt     <= '0;
      acc     <= '0;
      per_len <= base_len(idiv);
    end else if (tick) begin
      cnt     <= '0;
      acc     <= step[FRAC_W-1:0];
      per_len <= base_len(idiv) + per_t'(step[FRAC_W]);
    end else if (active) begin
      cnt     <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pclk_shaper.sv
module pclk_shaper
  import pclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              tick,
  input  logic              half,
  input  logic              a_bypass,
  input  logic [POST_W-1:0] a_post_n,
  input  logic              a_lead,
  input  logic              n_lead,
  input  logic              n_rest,
  output logic              running,
  output logic              end_first,
  output logic              end_second,
  output logic              pclk,
  output logic              pix_en
);
  logic  phase;
  tcnt_t tcnt;
  tcnt_t h1t;
  tcnt_t h2t;

  assign h1t = post_first(a_post_n);
  assign h2t = post_second(a_post_n);

  assign end_first  = running && !phase &&
                      (a_bypass ? half : (tick && tcnt == h1t - 1'b1));
  assign end_second = running && phase &&
                      (a_bypass ? tick : (tick && tcnt == h2t - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      phase   <= 1'b0;
      tcnt    <= '0;
      pclk    <= 1'b0;
      pix_en  <= 1'b0;
    end else begin
      pix_en <= 1'b0;
      if (!running) begin
        if (go) begin
          running <= 1'b1;
          phase   <= 1'b0;
          tcnt    <= '0;
          pclk    <= n_lead;
          pix_en  <= 1'b1;
        end else begin
          pclk    <= n_rest;
        end
      end else if (end_first || end_second) begin
        tcnt  <= '0;
        if (!go) begin
          running <= 1'b0;
          phase   <= 1'b0;
          pclk    <= n_rest;
        end else if (end_first) begin
          phase <= 1'b1;
          pclk  <= ~a_lead;
        end else begin
          phase  <= 1'b0;
          pclk   <= n_lead;
          pix_en <= 1'b1;
        end
      end else if (tick) begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pclk_gen.sv
module pclk_gen
  import pclk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] cfg_word,
  input  logic        run,
  output logic        pclk,
  output logic        pix_en
);
  pclk_cfg_t         live;
  pclk_cfg_t         act;
  logic              go;
  logic              load;
  logic              restart;
  logic              running;
  logic              tick;
  logic              half;
  logic              end_first;
  logic              end_second;
  per_t              per_len;
  logic [INT_W-1:0]  sel_idiv;
  logic [FRAC_W-1:0] sel_num;
  logic [FRAC_W-1:0] sel_den;
  logic [INT_W-1:0]  act_idiv;
  logic              act_lead;
  logic              act_unused;

  assign live     = pclk_cfg_t'(cfg_word);
  assign go       = run && (live.src != '0);
  assign load     = !running || end_second;
  assign restart  = !running && go;
  assign sel_idiv = load ? live.idiv : act.idiv;
  assign sel_num  = load ? live.num  : act.num;
  assign sel_den  = load ? live.den  : act.den;
  assign act_idiv = act.idiv;
  assign act_lead = act.lead_lvl;
  assign act_unused = ^{act.rest_lvl, act.src, act.force_on};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    act <= '0;
    else if (load) act <= live;
  end

  pclk_prediv u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (running),
    .restart (restart),
    .idiv    (sel_idiv),
    .num     (sel_num),
    .den     (sel_den),
    .tick    (tick),
    .half    (half),
    .per_len (per_len)
  );

  pclk_shaper u_shp (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .tick       (tick),
    .half       (half),
    .a_bypass   (act.bypass),
    .a_post_n   (act.post_n),
    .a_lead     (act.lead_lvl),
    .n_lead     (live.lead_lvl),
    .n_rest     (live.rest_lvl),
    .running    (running),
    .end_first  (end_first),
    .end_second (end_second),
    .pclk       (pclk),
    .pix_en     (pix_en)
  );
endmodule

// File: rtl/pclk_gen_chk.sv
module pclk_gen_chk
  import pclk_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             rest_now,
  input logic [SRC_W-1:0] src_now,
  input logic             pclk,
  input logic             pix_en,
  input logic             running,
  input logic             end_first,
  input logic             end_second,
  input per_t             per_len,
  input logic [INT_W-1:0] act_idiv,
  input logic             act_lead
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_IDLE_FOLLOWS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !running) |-> (pclk == $past(rest_now))); // R2

  AST_PULSE_AT_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en |-> (pclk == act_lead)); // R11

  AST_NO_PULSE_SRC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (src_now == '0) |=> !pix_en); // R9

  AST_EDGE_ONLY_AT_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && running && $past(running) && !$stable(pclk)) |->
      $past(end_first || end_second)); // R12

  AST_PRE_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (per_len == base_len(act_idiv) ||
                 per_len == base_len(act_idiv) + 1'b1)); // R6
endmodule

bind pclk_gen pclk_gen_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rest_now   (cfg_word[7]),
  .src_now    (cfg_word[30:29]),
  .pclk       (pclk),
  .pix_en     (pix_en),
  .running    (running),
  .end_first  (end_first),
  .end_second (end_second),
  .per_len    (per_len),
  .act_idiv   (act_idiv),
  .act_lead   (act_lead)
);

// File: tb/pclk_gen_test.sv
`timescale 1ns/1ps
module pclk_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg = '0;
  logic        run = 1'b0;
  logic        pclk;
  logic        pix_en;
  int          checks = 0;
  int          fails = 0;
  string       tag = "R1";

  always #2.5 clk = ~clk;

  pclk_gen uut (.clk(clk), .rst_n(rst_n), .cfg_word(cfg), .run(run),
                .pclk(pclk), .pix_en(pix_en));

  function automatic logic [31:0] mk(int n, int byp, int rest, int lead, int idiv,
                                     int num, int den, int src, int force_bit);
    logic [31:0] w;
    w = '0;
    w[5:0] = n[5:0]; w[6] = byp[0]; w[7] = rest[0]; w[8] = lead[0];
    w[16:9] = idiv[7:0]; w[22:17] = num[5:0]; w[28:23] = den[5:0];
    w[30:29] = src[1:0]; w[31] = force_bit[0];
    return w;
  endfunction

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // ---------------- behavioural reference model ----------------
  int m_on = 0, m_ph = 0, m_tk = 0, m_P = 1, m_el = 0, m_acc = 0;
  logic [31:0] m_cfg = '0;
  logic e_pclk = 1'b0, e_en = 1'b0;

  function automatic int eff(logic [7:0] i);
    return (i == 0) ? 256 : int'(i);
  endfunction

  function automatic int step_carry(logic [31:0] c, ref int acc);
    int num, den;
    num = c[22:17]; den = c[28:23];
    if (num == 0 || den == 0 || num >= den) begin acc = 0; return 0; end
    acc = acc + num;
    if (acc >= den) begin
      acc = acc - den;
      if (acc >= den) acc = 0;
      return 1;
    end
    return 0;
  endfunction

  always @(posedge clk) begin
    bit go, tk, hf, e1, e2;
    int n, tot, use_first, use_second, cy;
    logic [31:0] fc;
    if (!rst_n) begin
      m_on = 0; e_pclk = 0; e_en = 0; m_cfg = '0;
    end else begin
      go = run && (cfg[30:29] != 0);
      e_en = 0;
      if (m_on == 0) begin
        m_cfg = cfg;
        if (go) begin
          m_on = 1; m_ph = 0; m_tk = 0; m_el = 0; m_acc = 0;
          m_P = eff(cfg[16:9]); e_pclk = cfg[8]; e_en = 1;
        end else e_pclk = cfg[7];
      end else begin
        tk = (m_el == m_P - 1);
        hf = (m_P >= 2) && (m_el == (m_P + 1) / 2 - 1);
        n = (m_cfg[5:0] == 0) ? 1 : int'(m_cfg[5:0]);
        tot = n + 1; use_first = (tot + 1) / 2; use_second = tot / 2;
        e1 = (m_ph == 0) && (m_cfg[6] ? hf : (tk && m_tk + 1 == use_first));
        e2 = (m_ph == 1) && (m_cfg[6] ? tk : (tk && m_tk + 1 == use_second));
        if (tk) begin
          fc = e2 ? cfg : m_cfg;
          cy = step_carry(fc, m_acc);
          m_P = eff(fc[16:9]) + cy; m_el = 0;
        end else m_el++;
        if (e1 || e2) begin
          m_tk = 0;
          if (!go) begin m_on = 0; m_ph = 0; e_pclk = cfg[7]; end
          else if (e1) begin m_ph = 1; e_pclk = !m_cfg[8]; end
          else begin m_ph = 0; e_pclk = cfg[8]; e_en = 1; end
        end else if (tk) m_tk++;
        if (e2) m_cfg = cfg;
      end
    end
  end

  always @(negedge clk) begin
    chk({tag, " model pclk"}, int'(pclk), int'(e_pclk));
    chk({tag, " model pix_en"}, int'(pix_en), int'(e_en));
  end

  // ---------------- directed measurements ----------------
  task automatic period_stats(output int per, output int hi);
    while (!pix_en) @(negedge clk);
    per = 0; hi = 0;
    do begin
      if (pclk) hi++;
      per++;
      @(negedge clk);
    end while (!pix_en);
  endtask

  task automatic halt(int cyc);
    run = 1'b0;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic count_pulses(int cyc, output int cnt);
    cnt = 0;
    repeat (cyc) begin
      @(negedge clk);
      if (pix_en) cnt++;
    end
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    finish_up();
  end

  initial begin
    int per, hi, sum, cnt;
    repeat (3) @(negedge clk);
    tag = "R1";
    chk("R1 reset pclk", int'(pclk), 0);
    chk("R1 reset pix_en", int'(pix_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release pclk", int'(pclk), 0);

    tag = "R2";
    cfg = mk(3, 0, 1, 1, 2, 0, 0, 1, 0);
    repeat (2) @(negedge clk);
    chk("R2 idle high", int'(pclk), 1);
    cfg[7] = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 idle low", int'(pclk), 0);

    tag = "R3";
    cfg = mk(5, 1, 0, 1, 3, 0, 0, 2, 0); run = 1'b1;
    period_stats(per, hi);
    chk("R3 bypass period", per, 3);
    chk("R3 bypass first half", hi, 2);
    period_stats(per, hi);
    chk("R3 bypass period again", per, 3);
    halt(20);

    tag = "R4";
    cfg = mk(3, 0, 0, 1, 2, 0, 0, 1, 0); run = 1'b1;
    period_stats(per, hi);
    chk("R4 even post period", per, 8);
    chk("R4 even post high", hi, 4);
    halt(20);
    cfg = mk(2, 0, 0, 1, 2, 0, 0, 1, 0); run = 1'b1;
    period_stats(per, hi);
    chk("R4 odd post period", per, 6);
    chk("R4 odd post longer first half", hi, 4);
    halt(20);

    tag = "R5";
    cfg = mk(0, 0, 0, 1, 2, 0, 0, 3, 0); run = 1'b1;
    period_stats(per, hi);
    chk("R5 zero post count period", per, 4);
    chk("R5 zero post count high", hi, 2);
    halt(20);

    tag = "R6";
    cfg = mk(0, 1, 0, 1, 4, 1, 2, 1, 0); run = 1'b1;
    period_stats(per, hi);
    chk("R6 first pre-period", per, 4);
    period_stats(per, hi);
    chk("R6 second pre-period", per, 4);
    period_stats(per, hi);
    chk("R6 stretched pre-period", per, 5);
    sum = 0;
    for (int k = 0; k < 8; k++) begin
      period_stats(per, hi);
      sum += per;
    end
    chk("R6 average over eight periods", sum, 36);
    halt(20);

    tag = "R7";
    cfg = mk(0, 1, 0, 1, 4, 3, 2, 1, 0); run = 1'b1;
    sum = 0;
    for (int k = 0; k < 6; k++) begin
      period_stats(per, hi);
      sum += per;
    end
    chk("R7 numerator above denominator", sum, 24);
    halt(20);
    cfg = mk(0, 1, 0, 1, 4, 5, 0, 1, 0); run = 1'b1;
    sum = 0;
    for (int k = 0; k < 6; k++) begin
      period_stats(per, hi);
      sum += per;
    end
    chk("R7 zero denominator", sum, 24);
    halt(20);

    tag = "R8";
    cfg = mk(0, 1, 0, 1, 0, 0, 0, 1, 0); run = 1'b1;
    period_stats(per, hi);
    chk("R8 integer zero period", per, 256);
    chk("R8 integer zero high", hi, 128);
    halt(300);

    tag = "R9";
    cfg = mk(3, 0, 1, 0, 2, 0, 0, 0, 0); run = 1'b1;
    count_pulses(50, cnt);
    chk("R9 source off pulses", cnt, 0);
    chk("R9 source off level", int'(pclk), 1);
    cfg[30:29] = 2'd1;
    period_stats(per, hi);
    @(negedge clk);
    cfg[30:29] = 2'd0;
    count_pulses(40, cnt);
    chk("R9 source removed pulses", cnt, 0);
    chk("R9 source removed level", int'(pclk), 1);
    halt(20);

    tag = "R10";
    cfg = mk(3, 0, 0, 1, 2, 0, 0, 1, 0); run = 1'b1;
    while (!pix_en) @(negedge clk);
    run = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 half completes", int'(pclk), 1);
    repeat (2) @(negedge clk);
    chk("R10 idle at half boundary", int'(pclk), 0);
    count_pulses(30, cnt);
    chk("R10 no pulses after stop", cnt, 0);

    tag = "R11";
    cfg = mk(1, 0, 1, 0, 3, 0, 0, 1, 0); run = 1'b1;
    while (!pix_en) @(negedge clk);
    chk("R11 low lead level at pulse", int'(pclk), 0);
    period_stats(per, hi);
    chk("R11 low lead period", per, 6);
    chk("R11 low lead high cycles", hi, 3);
    halt(20);

    tag = "R12";
    cfg = mk(3, 0, 0, 1, 2, 0, 0, 1, 0); run = 1'b1;
    period_stats(per, hi);
    cfg[5:0] = 6'd1;
    period_stats(per, hi);
    chk("R12 current period kept", per, 8);
    period_stats(per, hi);
    chk("R12 next period changed", per, 4);
    halt(20);

    tag = "R13";
    cfg = mk(3, 0, 0, 1, 2, 0, 0, 1, 1); run = 1'b1;
    period_stats(per, hi);
    chk("R13 force bit period", per, 8);
    chk("R13 force bit high", hi, 4);
    halt(20);

    finish_up();
  end
endmodule